// File: doc/BRIEF.md
# Cascaded Interrupt Source Identifier

This block gathers up to 32 peripheral event lines behind a single input of a primary interrupt controller. Each event sets a sticky bit in a status register. An enable register gates which of those bits may raise the single combined interrupt line towards the primary controller. Both registers can be reached through a single-cycle register port.

Interrupt service code uses two operations. An identify request returns one pending, enabled source and masks it in the enable register. The source's status bit stays set, because the peripheral's own cause has not yet been handled. An end-of-interrupt request carries a source index and the count of handlers still outstanding. When that count is zero, the block clears the source's status bit and enables the source again. Any other count leaves the block unchanged. When several sources fire together, each needs its own identify and end-of-interrupt round.

Top module: `cascade_irq_ident`

## Requirements
- R1: After a synchronous active-high reset, status, enable, the combined output, the identify result and the read data are all zero.
- R2: A high event input sets its status bit, and the bit stays set after the event drops. An event and a clear of the same bit in one cycle leave the bit set.
- R3: Register address 0 selects status and address 1 selects enable. A write to status clears every bit written as one (write-one-to-clear). A write to enable replaces the register. A read returns the selected register one cycle later.
- R4: The combined output equals the OR of (status AND enable), registered one cycle after those registers change.
- R5: An identify returns a result and an acknowledge one cycle after the request. Result bit 5 is a valid flag and bits 4:0 hold the index of the highest-numbered set bit of status AND enable.
- R6: An identify when nothing is pending returns all-zero (valid clear) and leaves status and enable unchanged.
- R7: A successful identify clears the enable bit of the chosen source and leaves its status bit set.
- R8: An end-of-interrupt with a nonzero outstanding count changes neither register.
- R9: An end-of-interrupt with a zero count clears the indexed status bit and sets the indexed enable bit.
- R10: With two sources pending, the first identify reports the higher one, and the next identify reports the remaining one.
- R11: A status bit whose enable is clear is never chosen by identify and does not raise the combined output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 32 | Peripheral event lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = status, 1 = enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| id_req | input | 1 | Identify request |
| id_ack | output | 1 | Identify result valid this cycle |
| id_result | output | 6 | Bit 5 = source found, bits 4:0 = index |
| eoi_req | input | 1 | End-of-interrupt request |
| eoi_idx | input | 5 | Source index to complete |
| eoi_cnt | input | 8 | Outstanding handler count |
| irq_out | output | 1 | Combined interrupt towards primary controller |

## Verification
Identify is exercised with two sources pending at once, with the extreme indices 31 and 0, with an empty pending set, and with a high status bit whose enable is off. Together these separate highest-bit selection from lowest-bit selection, separate status-only from status-AND-enable decoding, and show whether the no-source path has side effects. End-of-interrupt is driven with both a nonzero and a zero count on the same source, which distinguishes the gated path from an unconditional clear. A write-one-to-clear that lands in the same cycle as an event checks the set-over-clear priority.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;
  typedef enum logic { REG_STATUS = 1'b0, REG_ENABLE = 1'b1 } reg_sel_e;
endpackage

// File: rtl/cirq_pick.sv
module cirq_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW:0] lz;

  // leading-zero count, then index = N-1 - lz
  always_comb begin
    lz = (IW+1)'(N);
    for (int i = 0; i < N; i++) begin
      if (pend[i]) lz = (IW+1)'(N - 1 - i);
    end
    found = (pend != '0);
    idx   = found ? IW'((IW+1)'(N - 1) - lz) : '0;
  end
endmodule

// File: rtl/cirq_regs.sv
module cirq_regs #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] st_clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] en_clr,
  input  logic [N-1:0] en_set,
  output logic [N-1:0] status_q,
  output logic [N-1:0] enable_q
);
  logic [N-1:0] en_base;

  always_comb en_base = en_wr ? en_wdata : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~st_clr) | evt;
      enable_q <= (en_base & ~en_clr) | en_set;
    end
  end
endmodule

// File: rtl/cascade_irq_ident.sv
module cascade_irq_ident
  import cascade_irq_pkg::*;
#(
  parameter int N    = 32,
  parameter int CNTW = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  evt_in,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  input  logic          id_req,
  output logic          id_ack,
  output logic [IW:0]   id_result,
  input  logic          eoi_req,
  input  logic [IW-1:0] eoi_idx,
  input  logic [CNTW-1:0] eoi_cnt,
  output logic          irq_out
);
  logic [N-1:0]  status_q, enable_q, pend;
  logic          pick_found;
  logic [IW-1:0] pick_idx;
  logic [N-1:0]  id_clr, eoi_hit, st_w1c, st_clr;
  logic          eoi_go, wr_stat, wr_en;

  always_comb begin
    pend    = status_q & enable_q;
    eoi_go  = eoi_req && (eoi_cnt == '0);
    wr_stat = reg_wr && (reg_addr == REG_STATUS);
    wr_en   = reg_wr && (reg_addr == REG_ENABLE);
    st_w1c  = wr_stat ? reg_wdata : '0;
    id_clr  = (id_req && pick_found) ? (N'(1) << pick_idx) : '0;
    eoi_hit = eoi_go ? (N'(1) << eoi_idx) : '0;
    st_clr  = st_w1c | eoi_hit;
  end

  cirq_pick #(.N(N), .IW(IW)) pick_i (
    .pend (pend),
    .found(pick_found),
    .idx  (pick_idx)
  );

  cirq_regs #(.N(N)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_in),
    .st_clr  (st_clr),
    .en_wr   (wr_en),
    .en_wdata(reg_wdata),
    .en_clr  (id_clr),
    .en_set  (eoi_hit),
    .status_q(status_q),
    .enable_q(enable_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      id_ack    <= 1'b0;
      id_result <= '0;
      irq_out   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      id_ack  <= id_req;
      irq_out <= |pend;
      if (id_req) id_result <= {pick_found, pick_idx};
      if (reg_rd) reg_rdata <= (reg_addr == REG_ENABLE) ? enable_q : status_q;
    end
  end
endmodule

// File: rtl/cirq_ident_chk.sv
module cirq_ident_chk #(
  parameter int N    = 32,
  parameter int CNTW = 8,
  localparam int IW  = $clog2(N)
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    evt_in,
  input logic            reg_wr,
  input logic            id_req,
  input logic            id_ack,
  input logic [IW:0]     id_result,
  input logic            eoi_req,
  input logic [CNTW-1:0] eoi_cnt,
  input logic            irq_out,
  input logic [N-1:0]    status_q,
  input logic [N-1:0]    enable_q
);
  // R2
  evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & $past(evt_in)) == $past(evt_in)));

  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(|(status_q & enable_q))));

  // R5
  id_ack_chk: assert property (@(posedge clk) disable iff (rst)
    id_req |=> id_ack);

  // R6
  id_none_chk: assert property (@(posedge clk) disable iff (rst)
    (id_ack && !id_result[IW]) |-> (id_result[IW-1:0] == '0));

  // R7
  id_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (id_ack && id_result[IW] && !$past(eoi_req) && !$past(reg_wr))
      |-> (!enable_q[id_result[IW-1:0]] && status_q[id_result[IW-1:0]]));

  // R8
  eoi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_req && eoi_cnt != '0 && !reg_wr && !id_req)
      |=> (enable_q == $past(enable_q)) && (status_q == ($past(status_q) | $past(evt_in))));
endmodule

bind cascade_irq_ident cirq_ident_chk #(.N(N), .CNTW(CNTW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .evt_in   (evt_in),
  .reg_wr   (reg_wr),
  .id_req   (id_req),
  .id_ack   (id_ack),
  .id_result(id_result),
  .eoi_req  (eoi_req),
  .eoi_cnt  (eoi_cnt),
  .irq_out  (irq_out),
  .status_q (status_q),
  .enable_q (enable_q)
);

// File: tb/cascade_irq_ident_tb_top.sv
module cascade_irq_ident_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        id_req = 1'b0, id_ack;
  logic [5:0]  id_result;
  logic        eoi_req = 1'b0;
  logic [4:0]  eoi_idx = '0;
  logic [7:0]  eoi_cnt = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;
  logic [5:0]  idv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ident dut_i (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .id_req(id_req), .id_ack(id_ack), .id_result(id_result),
    .eoi_req(eoi_req), .eoi_idx(eoi_idx), .eoi_cnt(eoi_cnt),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_evt(input logic [31:0] m);
    evt_in = m;
    tick();
    evt_in = '0;
  endtask

  task automatic ident(output logic [5:0] r);
    id_req = 1'b1;
    tick();
    id_req = 1'b0;
    check("R5 ack", {31'b0, id_ack}, 32'd1);
    r = id_result;
  endtask

  task automatic eoi(input logic [4:0] i, input logic [7:0] c);
    eoi_req = 1'b1; eoi_idx = i; eoi_cnt = c;
    tick();
    eoi_req = 1'b0;
  endtask

  task automatic regs_are(input string tag, input logic [31:0] st, input logic [31:0] en);
    logic [31:0] v;
    rd(1'b0, v); check({tag, " status"}, v, st);
    rd(1'b1, v); check({tag, " enable"}, v, en);
  endtask

  task automatic t_reset();
    check("R1 irq_out", {31'b0, irq_out}, 32'd0);
    check("R1 id_result", {26'b0, id_result}, 32'd0);
    check("R1 rdata", reg_rdata, 32'd0);
    regs_are("R1", 32'h0, 32'h0);
  endtask

  task automatic t_two_rounds();
    logic [5:0] r;
    wr(1'b1, 32'hFFFF_FFFF);
    regs_are("R3 enable write", 32'h0, 32'hFFFF_FFFF);
    pulse_evt(32'h0010_0020);
    check("R4 irq not yet", {31'b0, irq_out}, 32'd0);
    tick();
    check("R4 irq raised", {31'b0, irq_out}, 32'd1);
    regs_are("R2 sticky", 32'h0010_0020, 32'hFFFF_FFFF);
    ident(r);
    check("R5 highest idx 20", {26'b0, r}, 32'h34);
    regs_are("R7 mask kept status", 32'h0010_0020, 32'hFFEF_FFFF);
    eoi(5'd20, 8'd2);
    regs_are("R8 nonzero count", 32'h0010_0020, 32'hFFEF_FFFF);
    ident(r);
    check("R10 second round idx 5", {26'b0, r}, 32'h25);
    regs_are("R10 after second id", 32'h0010_0020, 32'hFFEF_FFDF);
    eoi(5'd20, 8'd0);
    regs_are("R9 eoi 20", 32'h0000_0020, 32'hFFFF_FFDF);
    eoi(5'd5, 8'd0);
    regs_are("R9 eoi 5", 32'h0, 32'hFFFF_FFFF);
    tick();
    check("R4 irq dropped", {31'b0, irq_out}, 32'd0);
  endtask

  task automatic t_empty();
    logic [5:0] r;
    ident(r);
    check("R6 no source", {26'b0, r}, 32'h00);
    regs_are("R6 unchanged", 32'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_disabled();
    logic [5:0] r;
    wr(1'b1, 32'h0000_000F);
    pulse_evt(32'h8000_0004);
    ident(r);
    check("R11 skip disabled 31", {26'b0, r}, 32'h22);
    eoi(5'd2, 8'd0);
    regs_are("R11 state", 32'h8000_0000, 32'h0000_000F);
    tick(); tick();
    check("R11 irq low", {31'b0, irq_out}, 32'd0);
    ident(r);
    check("R11 none enabled", {26'b0, r}, 32'h00);
    wr(1'b0, 32'h8000_0000);
    regs_are("R3 w1c", 32'h0, 32'h0000_000F);
  endtask

  task automatic t_set_over_clear();
    pulse_evt(32'h0000_0080);
    evt_in = 32'h0000_0080;
    wr(1'b0, 32'h0000_0080);
    evt_in = '0;
    regs_are("R2 set beats clear", 32'h0000_0080, 32'h0000_000F);
    wr(1'b0, 32'h0000_0080);
    regs_are("R3 w1c alone", 32'h0, 32'h0000_000F);
  endtask

  task automatic t_extremes();
    logic [5:0] r;
    wr(1'b1, 32'hFFFF_FFFF);
    pulse_evt(32'h8000_0001);
    ident(r);
    check("R5 idx 31", {26'b0, r}, 32'h3F);
    ident(r);
    check("R10 idx 0", {26'b0, r}, 32'h20);
    regs_are("R7 both masked", 32'h8000_0001, 32'h7FFF_FFFE);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_two_rounds();
    t_empty();
    t_disabled();
    t_set_over_clear();
    t_extremes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule